// File: doc/BRIEF.md
# Floating-Point Vector Max/Min Reduction Unit

This unit folds every floating-point lane of a 128-bit vector into one scalar that is either the largest or the smallest value. The fold starts from a scalar accumulator taken from a general-purpose register, and the result goes back to that same register. The unit handles half-precision or single-precision lanes. It supports plain signed comparison and a magnitude mode. In magnitude mode the sign of each vector lane is cleared before the comparison, but the seed keeps its own sign.

A caller raises `startValid` for one cycle and places the opcode fields, the register index, the seed and the vector on the inputs at the same time. The unit then folds one lane per cycle, starting at lane 0. After the last lane it pulses `done` with the result and the register index to write back.

NaN handling follows IEEE maxNum/minNum. A signalling-NaN seed is quieted once, when the seed is loaded. A start that arrives while the unit is working is dropped.

Top module: `vec_fminmax_reduce`

## Requirements
- R1: `opMin`=0 selects maximum and `opMin`=1 selects minimum. `opMode`=2'b10 selects signed comparison, and every other `opMode` code selects magnitude comparison.
- R2: The seed comes from `seedIn`. The result is presented on `resultOut`, and `resultReg` returns the `regIdx` value captured at start.
- R3: In magnitude mode each vector lane has its sign bit cleared before it is compared. The seed keeps its sign, so a negative seed can win a minimum.
- R4: A signalling-NaN seed has its quiet bit set once, when it is loaded, before any lane is compared. The accumulator never holds a signalling NaN.
- R5: When exactly one operand is a quiet NaN, the other operand is kept. When both operands are NaN, or a lane is a signalling NaN, the step produces the default NaN: 16'h7E00 for half precision and 32'h7FC00000 for single precision.
- R6: Signed zeros are ordered with -0 below +0. The maximum of +0 and -0 is +0, and the minimum is -0.
- R7: `opHalf`=1 gives 8 half-precision lanes, with lane i at bits [16i+15:16i]. `opHalf`=0 gives 4 single-precision lanes, with lane i at bits [32i+31:32i]. Lanes are folded from lane 0 upward, one per cycle.
- R8: In half-precision mode only `seedIn[15:0]` is used, and `resultOut[31:16]` is zero.
- R9: `busy` is high from the cycle after start is accepted until `done`. `done` is a one-cycle pulse that arrives 4 cycles after an accepted single-precision start, or 8 cycles after a half-precision start.
- R10: A `startValid` that arrives while `busy` is high is ignored. The running operation's result, its register index and its timing are not changed.
- R11: After reset, `busy` and `done` are low and `resultOut` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Start strobe; accepted only when idle |
| opHalf | input | 1 | 1 = half precision, 0 = single precision |
| opMin | input | 1 | 0 = maximum, 1 = minimum |
| opMode | input | 2 | 2'b10 = signed, any other code = magnitude |
| regIdx | input | 4 | Source/destination register index |
| seedIn | input | 32 | Seed accumulator value |
| vecIn | input | 128 | Vector operand, lane 0 in the low bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| resultOut | output | 32 | Reduced value, zero-extended in half mode |
| resultReg | output | 4 | Register index to write back |

## Verification
The start is sampled at edge 0. Lane k is folded at edge k+1, so `done` and the final `resultOut` appear after edge 4 for single precision and after edge 8 for half precision. Each scenario task drives its inputs at a falling edge, sees `busy` one edge later, and then steps one falling edge at a time. On every intermediate step it requires `done` to be low, and it reads the result only at the step where `done` is due. One edge later it checks that `done` has dropped. The busy-ignore scenario inserts a second start in the middle of an operation and uses the same cycle count to show that neither the timing nor the result moves.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int HALF_EXP = 5;
  localparam int HALF_MAN = 10;
  localparam int SGL_EXP  = 8;
  localparam int SGL_MAN  = 23;
  localparam int HALF_W   = 1 + HALF_EXP + HALF_MAN;
  localparam int SGL_W    = 1 + SGL_EXP + SGL_MAN;

  typedef struct packed {
    logic load;    // capture operands and seed
    logic fold;    // combine current lane into accumulator
    logic finish;  // this fold is the final lane
  } fpr_strobe_t;
endpackage

// File: rtl/fpr_pick.sv
module fpr_pick #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int W     = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] accIn,
  input  logic [W-1:0] elemIn,
  input  logic [W-1:0] seedIn,
  input  logic         wantMin,
  input  logic         absElem,
  output logic [W-1:0] resOut,
  output logic [W-1:0] seedOut
);
  localparam logic [W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  function automatic logic isNan(input logic [W-1:0] x);
    return (&x[W-2:MAN_W]) && (|x[MAN_W-1:0]);
  endfunction

  function automatic logic isSnan(input logic [W-1:0] x);
    return isNan(x) && !x[MAN_W-1];
  endfunction

  // a strictly below b in the total order with -0 < +0
  function automatic logic below(input logic [W-1:0] a, input logic [W-1:0] b);
    if (a[W-1] != b[W-1]) return a[W-1];
    else if (!a[W-1])     return a[W-2:0] < b[W-2:0];
    else                  return a[W-2:0] > b[W-2:0];
  endfunction

  logic [W-1:0] elemEff;
  logic accNan, elemNan, elemSig;

  always_comb begin
    elemEff = absElem ? {1'b0, elemIn[W-2:0]} : elemIn;
    accNan  = isNan(accIn);
    elemNan = isNan(elemEff);
    elemSig = isSnan(elemEff);
    if (elemSig || (accNan && elemNan)) resOut = DEF_NAN;
    else if (accNan)                    resOut = elemEff;
    else if (elemNan)                   resOut = accIn;
    else if (wantMin)                   resOut = below(elemEff, accIn) ? elemEff : accIn;
    else                                resOut = below(accIn, elemEff) ? elemEff : accIn;
  end

  always_comb begin
    seedOut = seedIn;
    if (isSnan(seedIn)) seedOut[MAN_W-1] = 1'b1;
  end

  always_comb begin
    if (!isNan(accIn) && !isNan(elemEff))
      AST_PICK_IS_OPERAND: assert (resOut == accIn || resOut == elemEff); // R1
  end
endmodule

// File: rtl/fpr_ctrl.sv
module fpr_ctrl #(
  parameter int VEC_W = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                startValid,
  input  logic                opHalf,
  output fpr_pkg::fpr_strobe_t strb,
  output logic                busy,
  output logic                done
);
  import fpr_pkg::*;
  localparam int HALF_LANES = VEC_W / HALF_W;
  localparam int SGL_LANES  = VEC_W / SGL_W;
  localparam int CNT_W      = $clog2(HALF_LANES);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_LANES - 1);
  localparam logic [CNT_W-1:0] SGL_LAST  = CNT_W'(SGL_LANES - 1);

  logic             runQ, doneQ, halfQ;
  logic [CNT_W-1:0] laneCnt;
  logic [CNT_W-1:0] lastIdx;

  assign lastIdx     = halfQ ? HALF_LAST : SGL_LAST;
  assign strb.load   = startValid && !runQ;
  assign strb.fold   = runQ;
  assign strb.finish = runQ && (laneCnt == lastIdx);
  assign busy        = runQ;
  assign done        = doneQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runQ    <= 1'b0;
      doneQ   <= 1'b0;
      halfQ   <= 1'b0;
      laneCnt <= '0;
    end else begin
      doneQ <= strb.finish;
      if (strb.load) begin
        runQ    <= 1'b1;
        halfQ   <= opHalf;
        laneCnt <= '0;
      end else if (strb.finish) begin
        runQ    <= 1'b0;
        laneCnt <= '0;
      end else if (strb.fold) begin
        laneCnt <= laneCnt + 1'b1;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    doneQ |=> !doneQ); // R9
  AST_LANE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    runQ |-> laneCnt <= lastIdx); // R7
  AST_START_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (runQ && !strb.finish) |=> (runQ && laneCnt == $past(laneCnt) + 1'b1)); // R10
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doneQ) |-> $past(runQ)); // R9
endmodule

// File: rtl/fpr_datapath.sv
module fpr_datapath #(
  parameter int VEC_W = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  fpr_pkg::fpr_strobe_t strb,
  input  logic                 opHalf,
  input  logic                 opMin,
  input  logic [1:0]           opMode,
  input  logic [3:0]           regIdx,
  input  logic [fpr_pkg::SGL_W-1:0] seedIn,
  input  logic [VEC_W-1:0]     vecIn,
  output logic [fpr_pkg::SGL_W-1:0] resultOut,
  output logic [3:0]           resultReg
);
  import fpr_pkg::*;
  localparam int PAD_W = SGL_W - HALF_W;

  logic [VEC_W-1:0] vecQ;
  logic [SGL_W-1:0] accQ;
  logic             halfQ, minQ, absQ;
  logic [3:0]       regQ;
  logic             magMode;

  logic [HALF_W-1:0] resH, seedH;
  logic [SGL_W-1:0]  resS, seedS;

  assign magMode = !(opMode[1] && !opMode[0]);

  fpr_pick #(.EXP_W(HALF_EXP), .MAN_W(HALF_MAN)) pickHalf (
    .accIn  (accQ[HALF_W-1:0]),
    .elemIn (vecQ[HALF_W-1:0]),
    .seedIn (seedIn[HALF_W-1:0]),
    .wantMin(minQ),
    .absElem(absQ),
    .resOut (resH),
    .seedOut(seedH)
  );

  fpr_pick #(.EXP_W(SGL_EXP), .MAN_W(SGL_MAN)) pickSgl (
    .accIn  (accQ),
    .elemIn (vecQ[SGL_W-1:0]),
    .seedIn (seedIn),
    .wantMin(minQ),
    .absElem(absQ),
    .resOut (resS),
    .seedOut(seedS)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vecQ  <= '0;
      accQ  <= '0;
      halfQ <= 1'b0;
      minQ  <= 1'b0;
      absQ  <= 1'b0;
      regQ  <= '0;
    end else if (strb.load) begin
      vecQ  <= vecIn;
      halfQ <= opHalf;
      minQ  <= opMin;
      absQ  <= magMode;
      regQ  <= regIdx;
      accQ  <= opHalf ? {{PAD_W{1'b0}}, seedH} : seedS;
    end else if (strb.fold) begin
      vecQ <= halfQ ? (vecQ >> HALF_W) : (vecQ >> SGL_W);
      accQ <= halfQ ? {{PAD_W{1'b0}}, resH} : resS;
    end
  end

  assign resultOut = accQ;
  assign resultReg = regQ;

  logic accSnan;
  always_comb begin
    if (halfQ)
      accSnan = (&accQ[HALF_W-2:HALF_MAN]) && (|accQ[HALF_MAN-1:0]) && !accQ[HALF_MAN-1];
    else
      accSnan = (&accQ[SGL_W-2:SGL_MAN]) && (|accQ[SGL_MAN-1:0]) && !accQ[SGL_MAN-1];
  end

  AST_ACC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    strb.fold |-> !accSnan); // R4
  AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (halfQ && strb.fold) |=> accQ[SGL_W-1:HALF_W] == '0); // R8
  AST_CTX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.fold && !strb.finish) |=> ($stable(regQ) && $stable(halfQ) && $stable(minQ))); // R10
endmodule

// File: rtl/vec_fminmax_reduce.sv
module vec_fminmax_reduce #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startValid,
  input  logic             opHalf,
  input  logic             opMin,
  input  logic [1:0]       opMode,
  input  logic [3:0]       regIdx,
  input  logic [31:0]      seedIn,
  input  logic [VEC_W-1:0] vecIn,
  output logic             busy,
  output logic             done,
  output logic [31:0]      resultOut,
  output logic [3:0]       resultReg
);
  fpr_pkg::fpr_strobe_t strb;

  fpr_ctrl #(.VEC_W(VEC_W)) ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startValid(startValid),
    .opHalf    (opHalf),
    .strb      (strb),
    .busy      (busy),
    .done      (done)
  );

  fpr_datapath #(.VEC_W(VEC_W)) dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .opHalf   (opHalf),
    .opMin    (opMin),
    .opMode   (opMode),
    .regIdx   (regIdx),
    .seedIn   (seedIn),
    .vecIn    (vecIn),
    .resultOut(resultOut),
    .resultReg(resultReg)
  );
endmodule

// File: tb/vec_fminmax_reduce_test.sv
module vec_fminmax_reduce_test;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         startValid = 1'b0;
  logic         opHalf = 1'b0;
  logic         opMin = 1'b0;
  logic [1:0]   opMode = 2'b10;
  logic [3:0]   regIdx = '0;
  logic [31:0]  seedIn = '0;
  logic [127:0] vecIn = '0;
  logic         busy, done;
  logic [31:0]  resultOut;
  logic [3:0]   resultReg;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  localparam logic [1:0] SIGNED_M = 2'b10;
  localparam logic [1:0] MAG_M    = 2'b00;

  vec_fminmax_reduce uut (
    .clk(clk), .rst_n(rst_n), .startValid(startValid), .opHalf(opHalf),
    .opMin(opMin), .opMode(opMode), .regIdx(regIdx), .seedIn(seedIn),
    .vecIn(vecIn), .busy(busy), .done(done), .resultOut(resultOut),
    .resultReg(resultReg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input string req, input logic half, input logic mn,
                       input logic [1:0] mode, input logic [3:0] rg,
                       input logic [31:0] seed, input logic [127:0] vec,
                       input logic [31:0] exp);
    int n;
    n = half ? 8 : 4;
    @(negedge clk);
    startValid = 1'b1; opHalf = half; opMin = mn; opMode = mode;
    regIdx = rg; seedIn = seed; vecIn = vec;
    @(negedge clk);
    startValid = 1'b0; seedIn = 32'hFFFF_FFFF; vecIn = '1;
    check({req, " R9 busy"}, {31'b0, busy}, 32'd1);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (k < n && done) check({req, " R9 early done"}, 32'd1, 32'd0);
    end
    check({req, " R9 done"}, {31'b0, done}, 32'd1);
    check({req, " result"}, resultOut, exp);
    check({req, " R2 reg"}, {28'b0, resultReg}, {28'b0, rg});
    @(negedge clk);
    check({req, " R9 pulse"}, {31'b0, done}, 32'd0);
  endtask

  task automatic testReset();
    check("R11 busy", {31'b0, busy}, 32'd0);
    check("R11 done", {31'b0, done}, 32'd0);
    check("R11 result", resultOut, 32'd0);
  endtask

  task automatic testSigned();
    // lanes {2.0, -5.0, 3.0, 0.5}
    runOp("R1 R7 smax", 0, 0, SIGNED_M, 4'd7, 32'h3F800000,
          {32'h40000000, 32'hC0A00000, 32'h40400000, 32'h3F000000}, 32'h40400000);
    runOp("R1 smin", 0, 1, SIGNED_M, 4'd3, 32'h3F800000,
          {32'h40000000, 32'hC0A00000, 32'h40400000, 32'h3F000000}, 32'hC0A00000);
    // opMode 2'b11 decodes as magnitude
    runOp("R1 mode11 mag", 0, 0, 2'b11, 4'd1, 32'h3F800000,
          {32'h40000000, 32'hC0A00000, 32'h40400000, 32'h3F000000}, 32'h40A00000);
  endtask

  task automatic testMagnitude();
    runOp("R3 magmax", 0, 0, MAG_M, 4'd2, 32'hBF800000,
          {32'h3F800000, 32'h40000000, 32'hC0A00000, 32'h3F000000}, 32'h40A00000);
    runOp("R3 magmin negseed", 0, 1, MAG_M, 4'd5, 32'hBF800000,
          {32'h3F800000, 32'hC0000000, 32'hC0A00000, 32'h3F000000}, 32'hBF800000);
  endtask

  task automatic testNan();
    runOp("R5 one qnan", 0, 0, SIGNED_M, 4'd9, 32'h7FC00001,
          {32'h3F800000, 32'h7FC00002, 32'h40000000, 32'h7FC00003}, 32'h40000000);
    runOp("R5 lanes all qnan", 0, 1, SIGNED_M, 4'd9, 32'h3F800000,
          {32'h7FC00004, 32'h7FC00003, 32'h7FC00002, 32'h7FC00001}, 32'h3F800000);
    runOp("R5 snan lane", 0, 0, SIGNED_M, 4'd9, 32'h3F800000,
          {32'h7F800001, 32'h3F800000, 32'h3F800000, 32'h3F800000}, 32'h7FC00000);
    runOp("R4 snan seed numeric", 0, 1, SIGNED_M, 4'd4, 32'h7F800001,
          {32'h40400000, 32'h3F000000, 32'h3F800000, 32'h40000000}, 32'h3F000000);
    runOp("R4 snan seed nan lanes", 0, 0, SIGNED_M, 4'd4, 32'h7F800001,
          {32'h7FC00005, 32'h7FC00005, 32'h7FC00005, 32'h7FC00005}, 32'h7FC00000);
  endtask

  task automatic testZeros();
    runOp("R6 max zero", 0, 0, SIGNED_M, 4'd0, 32'h00000000,
          {4{32'h80000000}}, 32'h00000000);
    runOp("R6 min zero", 0, 1, SIGNED_M, 4'd0, 32'h00000000,
          {4{32'h80000000}}, 32'h80000000);
    runOp("R6 max negseed", 0, 0, SIGNED_M, 4'd0, 32'h80000000,
          {4{32'h00000000}}, 32'h00000000);
  endtask

  task automatic testHalf();
    // lane 7 carries the winner so all 8 lanes must be folded
    runOp("R7 R8 hmax", 1, 0, SIGNED_M, 4'd11, 32'hDEAD3C00,
          {16'h4700, 16'h3800, 16'h3800, 16'h3800, 16'h3800, 16'hC200, 16'h4000, 16'h3800},
          32'h00004700);
    runOp("R8 R3 hmagmin", 1, 1, MAG_M, 4'd12, 32'hBEEF3C00,
          {16'hB400, 16'h4000, 16'h4000, 16'h4000, 16'hC000, 16'h4000, 16'h4000, 16'h4000},
          32'h00003400);
    runOp("R5 hsnan", 1, 0, SIGNED_M, 4'd13, 32'h00003C00,
          {16'h7D00, {7{16'h3C00}}}, 32'h00007E00);
  endtask

  task automatic testBusyIgnore();
    @(negedge clk);
    startValid = 1'b1; opHalf = 1'b0; opMin = 1'b0; opMode = SIGNED_M;
    regIdx = 4'd6; seedIn = 32'h3F800000;
    vecIn = {32'h3F000000, 32'h40400000, 32'h3F000000, 32'h3F000000};
    @(negedge clk);
    startValid = 1'b0;
    @(negedge clk);
    // second start mid-run with different operands
    startValid = 1'b1; opHalf = 1'b1; opMin = 1'b1; regIdx = 4'd14;
    seedIn = 32'hC2C80000; vecIn = '0;
    @(negedge clk);
    startValid = 1'b0;
    check("R10 no early done", {31'b0, done}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    check("R10 done on time", {31'b0, done}, 32'd1);
    check("R10 result kept", resultOut, 32'h40400000);
    check("R10 reg kept", {28'b0, resultReg}, 32'd6);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done) check("R10 second done", 32'd1, 32'd0);
    end
    check("R10 idle after", {31'b0, busy}, 32'd0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    testSigned();
    testMagnitude();
    testNan();
    testZeros();
    testHalf();
    testBusyIgnore();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end
endmodule